// File: doc/BRIEF.md
# Display Interrupt Status Latch

This block holds the non-maskable interrupt state of a raster display controller. It watches three sources: a display-list interrupt request carried by the current display instruction, the start of vertical blank, and an external reset key. When the horizontal cycle counter reaches one fixed position on the line, any pending source is recorded in a readable status byte. If that source is enabled, the active-low interrupt line is pulled low for a fixed number of cycles.

The display-list and vertical-blank status bits form an exclusive pair. Each new event of either kind sets its own bit and clears the other, so software finds out which kind came last without writing anything. The reset-key bit stands on its own. A key press is held pending and is reported together with the next vertical-blank event. Only a write to the status-reset address clears that bit. The display-list request bit is latched when an instruction is loaded and keeps its value until the next load. An old instruction can therefore still raise an interrupt while display-list fetching is stopped.

Top module: `dispirq_latch`

## Requirements
- R1: After synchronous reset the status byte reads 8'h1F and `nmi_n` is high. Both enables are cleared.
- R2: Events are taken only in a cycle where `hpos` equals FIRE_POS (default 8). A display-list event needs the latched request bit and `row_last` high. It sets status bit 7 and clears bit 6.
- R3: A vertical-blank event (`vblank_line` high at the firing position) sets status bit 6 and clears bit 7.
- R4: When both events occur in the same cycle, the vertical-blank event wins: bit 6 is set and bit 7 is cleared.
- R5: A rising edge on `rkey` is held pending and sets status bit 5 at the next vertical-blank event. Display-list and vertical-blank events leave bit 5 unchanged.
- R6: A write with `bus_addr`=1 clears status bits 7, 6 and 5. An event in the same cycle takes precedence and its bits are set.
- R7: Status bits 4..0 always read as 1.
- R8: A write with `bus_addr`=0 loads the enables: `bus_wdata[7]` enables the display-list interrupt and `bus_wdata[6]` the vertical-blank interrupt. An enabled event, or any reset-key event, drives `nmi_n` low for the PULSE_LEN (default 4) cycles that follow the event edge.
- R9: An event whose source is disabled still updates the status byte but leaves `nmi_n` high.
- R10: The display-list request bit is latched from `ir_dli` only when `ir_load` is high. Without a new load it keeps firing on every line with `row_last` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpos | input | HPOS_W | Horizontal cycle counter |
| ir_load | input | 1 | Display instruction register load strobe |
| ir_dli | input | 1 | Interrupt-request bit of the instruction being loaded |
| row_last | input | 1 | Current scan line is the last of its mode line |
| vblank_line | input | 1 | Current scan line starts vertical blank |
| rkey | input | 1 | Reset key level, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = enable register, 1 = status reset |
| bus_wdata | input | 8 | Write data |
| stat_rdata | output | 8 | Status byte: bit 7 display list, bit 6 vertical blank, bit 5 reset key |
| nmi_n | output | 1 | Active-low interrupt output |

## Verification
The hardest case to reach is a reset-key press that must wait across display-list events before it shows up. The stimulus presses the key, fires a display-list event and checks that bit 5 is still clear. Then a vertical-blank event sets bit 5 and fires the interrupt even with both enables off, and a later display-list event must leave bit 5 set. The stale-instruction case loads a request once and then fires several lines without any further load.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int STAT_W   = 8;
    localparam int BIT_DLI  = 7;
    localparam int BIT_VBI  = 6;
    localparam int BIT_RKEY = 5;

    typedef enum logic {
        ADDR_ENABLE  = 1'b0,
        ADDR_STATRST = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic dli;
        logic vbi;
        logic rkey;
    } irq_evt_t;

    typedef struct packed {
        logic dli;
        logic vbi;
        logic rkey;
    } irq_flags_t;

    function automatic logic [STAT_W-1:0] pack_status(input irq_flags_t f);
        logic [STAT_W-1:0] v;
        v = '1;
        v[BIT_DLI]  = f.dli;
        v[BIT_VBI]  = f.vbi;
        v[BIT_RKEY] = f.rkey;
        return v;
    endfunction

endpackage

// File: rtl/dispirq_event.sv
module dispirq_event
    import irq_stat_pkg::*;
#(
    parameter int HPOS_W   = 8,
    parameter int FIRE_POS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HPOS_W-1:0] hpos,
    input  logic              ir_load,
    input  logic              ir_dli,
    input  logic              row_last,
    input  logic              vblank_line,
    input  logic              rkey,
    output irq_evt_t          evt
);
    localparam logic [HPOS_W-1:0] FIRE_AT = HPOS_W'(FIRE_POS);

    logic fire;
    logic dli_arm;
    logic rkey_q;
    logic rkey_pend;
    logic rkey_rise;

    assign fire      = (hpos == FIRE_AT);
    assign rkey_rise = rkey & ~rkey_q;

    always_comb begin
        evt.vbi  = fire & vblank_line;
        evt.dli  = fire & dli_arm & row_last;
        evt.rkey = evt.vbi & (rkey_pend | rkey_rise);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dli_arm   <= 1'b0;
            rkey_q    <= 1'b0;
            rkey_pend <= 1'b0;
        end else begin
            rkey_q <= rkey;
            if (ir_load)
                dli_arm <= ir_dli;
            if (evt.rkey)
                rkey_pend <= 1'b0;
            else if (rkey_rise)
                rkey_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/dispirq_status.sv
module dispirq_status
    import irq_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  irq_evt_t          evt,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [1:0]        en_q,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              trig
);
    irq_flags_t flags;
    logic       wr_en_reg;
    logic       wr_clr;
    logic       unused_wbits;

    assign unused_wbits = ^bus_wdata[5:0];
    assign wr_en_reg    = bus_wr & (reg_addr_e'(bus_addr) == ADDR_ENABLE);
    assign wr_clr       = bus_wr & (reg_addr_e'(bus_addr) == ADDR_STATRST);

    // en_q[1] = display-list enable, en_q[0] = vertical-blank enable
    assign trig = (evt.vbi & en_q[0])
                | (evt.dli & ~evt.vbi & en_q[1])
                | evt.rkey;

    assign stat_rdata = pack_status(flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 2'b00;
            flags <= '0;
        end else begin
            if (wr_en_reg)
                en_q <= bus_wdata[7:6];
            if (wr_clr)
                flags <= '0;
            if (evt.vbi) begin
                flags.vbi <= 1'b1;
                flags.dli <= 1'b0;
            end else if (evt.dli) begin
                flags.dli <= 1'b1;
                flags.vbi <= 1'b0;
            end
            if (evt.rkey)
                flags.rkey <= 1'b1;
        end
    end
endmodule

// File: rtl/dispirq_pulse.sv
module dispirq_pulse #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic nmi_n
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic [CNT_W-1:0] cnt;

    assign nmi_n = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (trig)
            cnt <= CNT_W'(PULSE_LEN);
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end
endmodule

// File: rtl/dispirq_latch.sv
module dispirq_latch
    import irq_stat_pkg::*;
#(
    parameter int HPOS_W    = 8,
    parameter int FIRE_POS  = 8,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HPOS_W-1:0] hpos,
    input  logic              ir_load,
    input  logic              ir_dli,
    input  logic              row_last,
    input  logic              vblank_line,
    input  logic              rkey,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        stat_rdata,
    output logic              nmi_n
);
    irq_evt_t   evt;
    logic [1:0] en_q;
    logic       trig;

    dispirq_event #(.HPOS_W(HPOS_W), .FIRE_POS(FIRE_POS)) u_evt (
        .clk(clk), .rst(rst), .hpos(hpos), .ir_load(ir_load), .ir_dli(ir_dli),
        .row_last(row_last), .vblank_line(vblank_line), .rkey(rkey), .evt(evt)
    );

    dispirq_status u_stat (
        .clk(clk), .rst(rst), .evt(evt), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .en_q(en_q), .stat_rdata(stat_rdata), .trig(trig)
    );

    dispirq_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst(rst), .trig(trig), .nmi_n(nmi_n)
    );
endmodule

// File: rtl/dispirq_latch_chk.sv
module dispirq_latch_chk #(
    parameter int HPOS_W   = 8,
    parameter int FIRE_POS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [HPOS_W-1:0] hpos,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [7:0]        stat_rdata,
    input logic              nmi_n,
    input logic              evt_dli,
    input logic              evt_vbi,
    input logic              evt_rk,
    input logic [1:0]        en_q
);
    a_r7_unused_ones: assert property (@(posedge clk) disable iff (rst)
        stat_rdata[4:0] == 5'h1F);

    a_r2_fire_position: assert property (@(posedge clk) disable iff (rst)
        (evt_dli || evt_vbi) |-> (hpos == HPOS_W'(FIRE_POS)));

    a_r2_dli_sets: assert property (@(posedge clk) disable iff (rst)
        (evt_dli && !evt_vbi) |=> (stat_rdata[7:6] == 2'b10));

    a_r4_vbi_wins: assert property (@(posedge clk) disable iff (rst)
        evt_vbi |=> (stat_rdata[7:6] == 2'b01));

    a_r3_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(stat_rdata[7] && stat_rdata[6]));

    a_r5_rkey_sets: assert property (@(posedge clk) disable iff (rst)
        evt_rk |=> stat_rdata[5]);

    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr && !evt_dli && !evt_vbi) |=> (stat_rdata[7:5] == 3'b000));

    a_r8_vbi_pulse: assert property (@(posedge clk) disable iff (rst)
        ((evt_vbi && en_q[0]) || evt_rk) |=> !nmi_n);

    a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (rst)
        (nmi_n && !evt_dli && !evt_vbi) |=> nmi_n);
endmodule

bind dispirq_latch dispirq_latch_chk #(.HPOS_W(HPOS_W), .FIRE_POS(FIRE_POS)) u_chk (
    .clk(clk), .rst(rst), .hpos(hpos), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .stat_rdata(stat_rdata), .nmi_n(nmi_n), .evt_dli(evt.dli), .evt_vbi(evt.vbi),
    .evt_rk(evt.rkey), .en_q(en_q)
);

// File: tb/dispirq_latch_tb.sv
module dispirq_latch_tb;
    localparam int FIRE = 8;
    localparam int PLEN = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] hpos;
    logic       ir_load, ir_dli, row_last, vblank_line, rkey;
    logic       bus_wr, bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] stat_rdata;
    logic       nmi_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dispirq_latch #(.HPOS_W(8), .FIRE_POS(FIRE), .PULSE_LEN(PLEN)) u_dut (
        .clk(clk), .rst(rst), .hpos(hpos), .ir_load(ir_load), .ir_dli(ir_dli),
        .row_last(row_last), .vblank_line(vblank_line), .rkey(rkey),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .stat_rdata(stat_rdata), .nmi_n(nmi_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIAL_%s", "");
        end
    endtask

    task automatic ck(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        hpos = 8'd20; row_last = 1'b0; vblank_line = 1'b0;
        for (int i = 0; i < PLEN + 2; i++) tick();
    endtask

    task automatic wreg(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic load_ir(input logic d);
        ir_load = 1'b1; ir_dli = d;
        tick();
        ir_load = 1'b0; ir_dli = 1'b0;
    endtask

    task automatic fire_line(input logic rl, input logic vb);
        hpos = FIRE[7:0]; row_last = rl; vblank_line = vb;
        tick();
        hpos = 8'd20; row_last = 1'b0; vblank_line = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; hpos = 0; ir_load = 0; ir_dli = 0; row_last = 0;
        vblank_line = 0; rkey = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        tick(); tick();
        rst = 1'b0;
        tick();
        ck("R1 reset status", stat_rdata, 8'h1F);
        ck("R1 reset nmi_n", {7'd0, nmi_n}, 8'd1);
        ck("R7 low bits", {3'd0, stat_rdata[4:0]}, 8'h1F);
    endtask

    task automatic t_dli();
        wreg(1'b0, 8'hC0);
        load_ir(1'b1);
        hpos = 8'd7; row_last = 1'b1;
        tick();
        ck("R2 off-position ignored", stat_rdata, 8'h1F);
        ck("R2 off-position nmi_n", {7'd0, nmi_n}, 8'd1);
        fire_line(1'b1, 1'b0);
        ck("R2 dli sets bit7", stat_rdata, 8'h9F);
        ck("R8 nmi low first", {7'd0, nmi_n}, 8'd0);
        tick(); tick(); tick();
        ck("R8 nmi low last", {7'd0, nmi_n}, 8'd0);
        tick();
        ck("R8 nmi released", {7'd0, nmi_n}, 8'd1);
        wait_idle();
    endtask

    task automatic t_vbi();
        fire_line(1'b0, 1'b1);
        ck("R3 vbi sets bit6 clears bit7", stat_rdata, 8'h5F);
        ck("R8 vbi nmi", {7'd0, nmi_n}, 8'd0);
        wait_idle();
        fire_line(1'b1, 1'b0);
        ck("R3 dli after vbi swaps", stat_rdata, 8'h9F);
        wait_idle();
        fire_line(1'b1, 1'b1);
        ck("R4 vbi wins tie", stat_rdata, 8'h5F);
        wait_idle();
    endtask

    task automatic t_clear();
        wreg(1'b1, 8'h00);
        ck("R6 clear", stat_rdata, 8'h1F);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h00;
        fire_line(1'b0, 1'b1);
        bus_wr = 1'b0;
        ck("R6 event beats clear", stat_rdata, 8'h5F);
        wait_idle();
        wreg(1'b1, 8'h00);
    endtask

    task automatic t_rkey_masked();
        wreg(1'b0, 8'h00);
        fire_line(1'b1, 1'b0);
        ck("R9 masked dli status", stat_rdata, 8'h9F);
        ck("R9 masked dli nmi_n", {7'd0, nmi_n}, 8'd1);
        tick();
        ck("R9 masked dli nmi_n later", {7'd0, nmi_n}, 8'd1);
        rkey = 1'b1; tick(); rkey = 1'b0; tick();
        fire_line(1'b1, 1'b0);
        ck("R5 key waits for vbi", stat_rdata, 8'h9F);
        ck("R9 no nmi", {7'd0, nmi_n}, 8'd1);
        fire_line(1'b0, 1'b1);
        ck("R5 key reported with vbi", stat_rdata, 8'h7F);
        ck("R8 key nmi unmaskable", {7'd0, nmi_n}, 8'd0);
        wait_idle();
        fire_line(1'b1, 1'b0);
        ck("R5 bit5 kept by dli", stat_rdata, 8'hBF);
        wait_idle();
        fire_line(1'b0, 1'b1);
        ck("R5 key consumed once", stat_rdata, 8'h7F);
        ck("R9 masked vbi no nmi", {7'd0, nmi_n}, 8'd1);
        wreg(1'b1, 8'h00);
        ck("R6 clears bit5", stat_rdata, 8'h1F);
    endtask

    task automatic t_stale();
        wreg(1'b0, 8'h80);
        for (int k = 0; k < 3; k++) begin
            wreg(1'b1, 8'h00);
            fire_line(1'b1, 1'b0);
            ck("R10 stale request fires", stat_rdata, 8'h9F);
            ck("R10 stale nmi", {7'd0, nmi_n}, 8'd0);
            wait_idle();
        end
        load_ir(1'b0);
        wreg(1'b1, 8'h00);
        fire_line(1'b1, 1'b0);
        ck("R10 new load drops request", stat_rdata, 8'h1F);
        ck("R10 no nmi", {7'd0, nmi_n}, 8'd1);
    endtask

    initial begin
        t_reset();
        t_dli();
        t_vbi();
        t_clear();
        t_rkey_masked();
        t_stale();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule